// File: doc/BRIEF.md
# Kernel body termination sequencer

This block follows the execution of an out-of-line kernel body. A launch pulse hands it the body entry address and the continuation address the header computed. From then on it watches one decoded instruction class per cycle, together with a flag that says whether the fetch at the current body address found legal code. It keeps the body program counter up to date across sequential steps and direct branch or jump redirects, and it publishes that counter so the fetch side knows where to read next.

The first terminator the body reaches ends the kernel. A stop marker and any block-start marker count as terminators, and a block-start marker only closes the kernel. It is never launched as a nested block. On completion the block pulses `done` and presents the continuation address. Three situations raise a one-cycle fault pulse with a one-hot cause code, after which the sequencer goes idle: fetching beyond valid code, reserved control flow, and a header descriptor inside the body. A body that loops forever is legal, so there is no timeout.

Top module: `kbody_term_seq`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `done`, `fault` and `fault_code` are all 0.
- R2: A `start` pulse while idle latches the addresses. One cycle later `busy` is 1 and `body_pc` equals `entry_addr`.
- R3: An accepted instruction of class PLAIN (0), or a BRANCH (1) with `ins_taken`=0, advances `body_pc` by `ins_len` bytes in the next cycle. Codes 12 to 15 also act as PLAIN.
- R4: A BRANCH (1) with `ins_taken`=1, or a JUMP (2), loads `body_pc` with `ins_target` in the next cycle. A later terminator at that target ends the kernel normally.
- R5: A STOP (3) or compressed STOP (4) produces a `done` pulse of exactly one cycle in the next cycle. In that cycle `ret_addr` equals the latched `cont_addr` and `busy` is 0.
- R6: A block-start marker in normal (5), compressed (6) or high-long (7) form ends the kernel exactly like a stop. `ret_addr` is the continuation address and no new body begins.
- R7: After a kernel ends, further instructions produce neither `done` nor `fault`, and they leave `body_pc` unchanged. `done` and `fault` are never high together.
- R8: An accepted instruction with `ins_fetch_ok`=0 raises a one-cycle `fault` with `fault_code`=3'b001, and `busy` drops. `fault_code` is 0 whenever `fault` is 0.
- R9: An indirect jump (8), call (9) or return (10) raises `fault` with `fault_code`=3'b010.
- R10: A header descriptor (11) inside the body raises `fault` with `fault_code`=3'b100.
- R11: No number of cycles ends a running body. `busy` stays 1 through thousands of self-loop jumps and also while no instruction is presented.
- R12: A `start` while `busy` is ignored. `body_pc` and the continuation address are kept.
- R13: During a fault pulse, `fault_pc` holds the body address of the offending instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch pulse for a kernel body |
| entry_addr | input | AW | Body entry address from the header |
| cont_addr | input | AW | Header continuation address |
| ins_valid | input | 1 | A decoded instruction for `body_pc` is presented |
| ins_fetch_ok | input | 1 | Fetch at `body_pc` found valid body code |
| ins_class | input | 4 | Decoded instruction class code |
| ins_len | input | LW | Instruction length in bytes |
| ins_taken | input | 1 | Direct branch condition resolved true |
| ins_target | input | AW | Direct branch or jump target |
| busy | output | 1 | A kernel body is running |
| body_pc | output | AW | Current body address to fetch |
| done | output | 1 | One-cycle completion pulse |
| ret_addr | output | AW | Resume address, valid with `done` |
| fault | output | 1 | One-cycle fault pulse |
| fault_code | output | 3 | One-hot cause: bit 0 fetch, bit 1 reserved flow, bit 2 format |
| fault_pc | output | AW | Address of the faulting instruction |

## Verification
The hardest case to reach from the ports is a long-running body that must never time out, together with the moment right after termination, when stray instructions must be silently dropped. The stimulus drives thousands of self-targeting jumps before it sends a stop. It then feeds plain and block-start instructions into the idle sequencer. A scoreboard expects exactly one completion or fault event per kernel, so any spurious or missing pulse is caught.

// File: rtl/kbseq_pkg.sv
package kbseq_pkg;
  typedef enum logic [3:0] {
    CLS_PLAIN    = 4'd0,
    CLS_BRANCH   = 4'd1,
    CLS_JUMP     = 4'd2,
    CLS_STOP     = 4'd3,
    CLS_STOP_C   = 4'd4,
    CLS_BSTART   = 4'd5,
    CLS_BSTART_C = 4'd6,
    CLS_BSTART_H = 4'd7,
    CLS_IND_JUMP = 4'd8,
    CLS_CALL     = 4'd9,
    CLS_RET      = 4'd10,
    CLS_HDR_DESC = 4'd11
  } ins_class_e;

  localparam int FCW = 3;
  localparam logic [FCW-1:0] FC_FETCH = 3'b001;
  localparam logic [FCW-1:0] FC_RESV  = 3'b010;
  localparam logic [FCW-1:0] FC_FMT   = 3'b100;
endpackage

// File: rtl/kbseq_classify.sv
module kbseq_classify
  import kbseq_pkg::*;
(
  input  logic [3:0] cls_i,
  input  logic       taken_i,
  output logic       term_o,
  output logic       resv_o,
  output logic       hdr_o,
  output logic       redir_o
);
  ins_class_e cls;
  assign cls = ins_class_e'(cls_i);

  always_comb begin
    term_o  = 1'b0;
    resv_o  = 1'b0;
    hdr_o   = 1'b0;
    redir_o = 1'b0;
    case (cls)
      CLS_STOP, CLS_STOP_C,
      CLS_BSTART, CLS_BSTART_C, CLS_BSTART_H: term_o  = 1'b1;
      CLS_IND_JUMP, CLS_CALL, CLS_RET:        resv_o  = 1'b1;
      CLS_HDR_DESC:                           hdr_o   = 1'b1;
      CLS_JUMP:                               redir_o = 1'b1;
      CLS_BRANCH:                             redir_o = taken_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/kbseq_pc.sv
module kbseq_pc #(
  parameter int AW = 32,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          step_i,
  input  logic          redir_i,
  input  logic [AW-1:0] target_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] pc_o
);
  function automatic logic [AW-1:0] seq_next(input logic [AW-1:0] a,
                                             input logic [LW-1:0] n);
    return a + AW'(n);
  endfunction

  logic [AW-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (load_i) begin
      pc_q <= load_addr_i;
    end else if (step_i) begin
      pc_q <= redir_i ? target_i : seq_next(pc_q, len_i);
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/kbody_term_seq.sv
module kbody_term_seq
  import kbseq_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] entry_addr,
  input  logic [AW-1:0] cont_addr,
  input  logic          ins_valid,
  input  logic          ins_fetch_ok,
  input  logic [3:0]    ins_class,
  input  logic [LW-1:0] ins_len,
  input  logic          ins_taken,
  input  logic [AW-1:0] ins_target,
  output logic          busy,
  output logic [AW-1:0] body_pc,
  output logic          done,
  output logic [AW-1:0] ret_addr,
  output logic          fault,
  output logic [2:0]    fault_code,
  output logic [AW-1:0] fault_pc
);
  logic          busy_q, done_q, fault_q;
  logic [FCW-1:0] code_q;
  logic [AW-1:0] cont_q, fpc_q;

  logic is_term, is_resv, is_hdr, is_redir;

  // Named events for the checks below.
  logic ev_launch, ev_accept, ev_bad_fetch, ev_term, ev_resv, ev_hdr, ev_step, ev_fault;
  logic [FCW-1:0] ev_code;

  kbseq_classify u_cls (
    .cls_i   (ins_class),
    .taken_i (ins_taken),
    .term_o  (is_term),
    .resv_o  (is_resv),
    .hdr_o   (is_hdr),
    .redir_o (is_redir)
  );

  assign ev_launch    = start && !busy_q;
  assign ev_accept    = busy_q && ins_valid;
  assign ev_bad_fetch = ev_accept && !ins_fetch_ok;
  assign ev_term      = ev_accept && ins_fetch_ok && is_term;
  assign ev_resv      = ev_accept && ins_fetch_ok && is_resv;
  assign ev_hdr       = ev_accept && ins_fetch_ok && is_hdr;
  assign ev_step      = ev_accept && ins_fetch_ok && !is_term && !is_resv && !is_hdr;
  assign ev_fault     = ev_bad_fetch || ev_resv || ev_hdr;
  assign ev_code      = ev_bad_fetch ? FC_FETCH : (ev_resv ? FC_RESV : (ev_hdr ? FC_FMT : '0));

  kbseq_pc #(.AW(AW), .LW(LW)) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (ev_launch),
    .load_addr_i (entry_addr),
    .step_i      (ev_step),
    .redir_i     (is_redir),
    .target_i    (ins_target),
    .len_i       (ins_len),
    .pc_o        (body_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      code_q  <= '0;
      cont_q  <= '0;
      fpc_q   <= '0;
    end else begin
      done_q  <= ev_term;
      fault_q <= ev_fault;
      code_q  <= ev_code;
      if (ev_fault) fpc_q <= body_pc;
      if (ev_launch) begin
        busy_q <= 1'b1;
        cont_q <= cont_addr;
      end else if (ev_term || ev_fault) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign ret_addr   = cont_q;
  assign fault      = fault_q;
  assign fault_code = code_q;
  assign fault_pc   = fpc_q;

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |=> (body_pc == $past(entry_addr)) && busy);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
  assert_code_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($countones(fault_code) == 1) && !busy);
  assert_code_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> (fault_code == '0));
  assert_no_timeout_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ins_valid) |=> busy);
  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !ins_valid) |=> $stable(body_pc) && $stable(ret_addr) && busy);
endmodule

// File: tb/kbody_term_seq_test.sv
`timescale 1ns/1ps
module kbody_term_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] entry_addr = '0, cont_addr = '0;
  logic        ins_valid = 1'b0, ins_fetch_ok = 1'b1, ins_taken = 1'b0;
  logic [3:0]  ins_class = '0;
  logic [2:0]  ins_len = '0;
  logic [31:0] ins_target = '0;
  logic        busy, done, fault;
  logic [31:0] body_pc, ret_addr, fault_pc;
  logic [2:0]  fault_code;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_pc;

  typedef struct {
    bit          is_fault;
    logic [2:0]  code;
    logic [31:0] addr;
    string       req;
  } sb_item_t;
  sb_item_t sb[$];
  sb_item_t mon_item;

  always #4 clk = ~clk;

  kbody_term_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .entry_addr(entry_addr), .cont_addr(cont_addr),
    .ins_valid(ins_valid), .ins_fetch_ok(ins_fetch_ok), .ins_class(ins_class), .ins_len(ins_len),
    .ins_taken(ins_taken), .ins_target(ins_target), .busy(busy), .body_pc(body_pc), .done(done),
    .ret_addr(ret_addr), .fault(fault), .fault_code(fault_code), .fault_pc(fault_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: every done/fault pulse must match the oldest expectation.
  always @(posedge clk) begin
    #1;
    if (rst_n && (done || fault)) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected event done=%b fault=%b expected none", done, fault);
      end else begin
        mon_item = sb.pop_front();
        if (mon_item.is_fault) begin
          if (!fault || done || fault_code !== mon_item.code || fault_pc !== mon_item.addr) begin
            errors++;
            $display("FAIL %s actual fault=%b code=%b pc=%h expected fault=1 code=%b pc=%h",
                     mon_item.req, fault, fault_code, fault_pc, mon_item.code, mon_item.addr);
          end
        end else begin
          if (!done || fault || ret_addr !== mon_item.addr || busy) begin
            errors++;
            $display("FAIL %s actual done=%b ret=%h busy=%b expected done=1 ret=%h busy=0",
                     mon_item.req, done, ret_addr, busy, mon_item.addr);
          end
        end
      end
    end
  end

  task automatic expect_done(input logic [31:0] ret, input string req);
    sb_item_t it;
    it.is_fault = 0; it.code = 3'b000; it.addr = ret; it.req = req;
    sb.push_back(it);
  endtask

  task automatic expect_fault(input logic [2:0] code, input logic [31:0] pc, input string req);
    sb_item_t it;
    it.is_fault = 1; it.code = code; it.addr = pc; it.req = req;
    sb.push_back(it);
  endtask

  task automatic issue(input logic [3:0] c, input logic [2:0] l, input logic tk,
                       input logic [31:0] tg, input logic ok);
    ins_valid = 1'b1; ins_class = c; ins_len = l; ins_taken = tk;
    ins_target = tg; ins_fetch_ok = ok;
    @(posedge clk); #1;
    ins_valid = 1'b0; ins_taken = 1'b0; ins_fetch_ok = 1'b1;
  endtask

  task automatic launch(input logic [31:0] ent, input logic [31:0] cnt);
    start = 1'b1; entry_addr = ent; cont_addr = cnt;
    @(posedge clk); #1;
    start = 1'b0;
    exp_pc = ent;
    chk("R2 pc", body_pc, exp_pc);
    chk("R2 busy", {31'b0, busy}, 32'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy in reset", {31'b0, busy}, 0);
    chk("R1 done/fault in reset", {30'b0, done, fault}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 code", {29'b0, fault_code}, 0);

    // Sequential stepping and redirects
    launch(32'h1000, 32'h2000);
    issue(4'd0, 3'd4, 0, 0, 1); exp_pc = exp_pc + 4;
    chk("R3 plain len4", body_pc, exp_pc);
    issue(4'd0, 3'd2, 0, 0, 1); exp_pc = exp_pc + 2;
    chk("R3 plain len2", body_pc, exp_pc);
    issue(4'd1, 3'd4, 0, 32'h9999, 1); exp_pc = exp_pc + 4;
    chk("R3 branch not taken", body_pc, exp_pc);
    issue(4'd13, 3'd6, 0, 0, 1); exp_pc = exp_pc + 6;
    chk("R3 unassigned code", body_pc, exp_pc);
    issue(4'd1, 3'd4, 1, 32'h1100, 1); exp_pc = 32'h1100;
    chk("R4 branch taken", body_pc, exp_pc);
    issue(4'd2, 3'd4, 0, 32'h1200, 1); exp_pc = 32'h1200;
    chk("R4 jump", body_pc, exp_pc);
    // Start while busy is ignored
    start = 1'b1; entry_addr = 32'h7770; cont_addr = 32'h8880;
    @(posedge clk); #1; start = 1'b0;
    chk("R12 pc kept", body_pc, exp_pc);
    chk("R12 busy kept", {31'b0, busy}, 1);
    expect_done(32'h2000, "R5 stop");
    issue(4'd3, 3'd4, 0, 0, 1);
    idle(1);
    chk("R5 done single cycle", {31'b0, done}, 0);
    // Instructions after termination are dropped
    issue(4'd0, 3'd4, 0, 0, 1);
    issue(4'd5, 3'd4, 0, 0, 1);
    issue(4'd8, 3'd4, 0, 0, 1);
    idle(1);
    chk("R7 pc frozen", body_pc, exp_pc);
    chk("R7 still idle", {31'b0, busy}, 0);

    // Compressed stop after jump to terminator
    launch(32'h4000, 32'h4800);
    issue(4'd2, 3'd2, 0, 32'h4040, 1); exp_pc = 32'h4040;
    chk("R4 jump to terminator", body_pc, exp_pc);
    expect_done(32'h4800, "R4 terminator at target");
    issue(4'd4, 3'd2, 0, 0, 1);
    idle(1);

    // Block-start forms end the kernel
    for (int k = 5; k <= 7; k++) begin
      launch(32'h5000 + 32'(k) * 32'h100, 32'h6000 + 32'(k));
      issue(4'd0, 3'd4, 0, 0, 1);
      expect_done(32'h6000 + 32'(k), "R6 block start");
      issue(4'(k), 3'd4, 0, 0, 1);
      idle(1);
      chk("R6 no nested body", {31'b0, busy}, 0);
      chk("R6 pc unchanged", body_pc, exp_pc + 4);
    end

    // Fetch past valid code
    launch(32'hA000, 32'hB000);
    issue(4'd0, 3'd4, 0, 0, 1); exp_pc = exp_pc + 4;
    expect_fault(3'b001, exp_pc, "R8 fetch fault");
    issue(4'd0, 3'd4, 0, 0, 0);
    chk("R8 busy dropped", {31'b0, busy}, 0);
    idle(1);
    chk("R8 pulse one cycle", {28'b0, fault, fault_code}, 0);

    // Reserved control flow
    for (int k = 8; k <= 10; k++) begin
      launch(32'hC000 + 32'(k) * 32'h10, 32'hD000);
      expect_fault(3'b010, exp_pc, "R9 reserved flow");
      issue(4'(k), 3'd4, 0, 32'h1234, 1);
      idle(1);
    end

    // Header descriptor inside body
    launch(32'hE000, 32'hF000);
    issue(4'd0, 3'd2, 0, 0, 1); exp_pc = exp_pc + 2;
    expect_fault(3'b100, exp_pc, "R10 header in body R13");
    issue(4'd11, 3'd4, 0, 0, 1);
    idle(1);

    // Long self loop, no timeout
    launch(32'h3000, 32'h3800);
    for (int i = 0; i < 3000; i++) issue(4'd2, 3'd4, 0, 32'h3000, 1);
    idle(20);
    chk("R11 still busy", {31'b0, busy}, 1);
    chk("R11 pc on loop", body_pc, 32'h3000);
    expect_done(32'h3800, "R11 loop exit");
    issue(4'd3, 3'd4, 0, 0, 1);
    idle(3);

    chk("R5 all events seen", sb.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule